// File: doc/BRIEF.md
# SPI Shift Unit with Stop-State Freeze

This block is an 8-bit SPI shift engine that can act as bus master or as slave, reached through three byte-wide registers for control, status and data. Its one distinctive property is how it behaves while the surrounding system sits in a stop state. A single-cycle `stop_i` pulse puts the block into that state. An `irq_wake_i` pulse takes it out again, and so does the asynchronous reset.

In master mode the bit-rate divider is frozen while stopped, so a frame in flight pauses with SCK and MOSI held at their current levels. After the wake it carries on from the same bit. In slave mode the shifter keeps running on the external clock while stopped, taking in MOSI and driving MISO. However, the completion flag is held back: a frame that finishes during stop is remembered and its flag is posted on the first cycle after the wake.

Clock polarity, clock phase and a four-step master divider are selected in the control register. A reset clears every control and status bit, which leaves the unit disabled.

Top module: `spi_stopfreeze`

## Requirements
- R1: While stopped, an active master frame does not advance. `sck_o`, `mosi_o` and the busy bit (status bit 6) hold their values for as long as the stop state lasts. The stop state is entered by a one-cycle `stop_i` pulse and left by a one-cycle `irq_wake_i` pulse; wake wins if both arrive together.
- R2: After an IRQ wake, a paused master frame completes its remaining bits. The received byte and the completion flag are the same as for an uninterrupted frame.
- R3: `rst_ni` low clears the control register (reads 0x00), the status register (reads 0x00) and the stop state, and returns `sck_o` low and `ss_no` high. With the enable bit at 0, a write to the data register starts no frame and `ss_no` stays high.
- R4: In slave mode during stop, the unit still samples MOSI on the external SCK and shifts its transmit byte out on `miso_o`.
- R5: The completion flag (status bit 7) never becomes set while the block is stopped.
- R6: A slave frame that completes during stop sets the completion flag in the first cycle after the wake. The flag is still clear at the clock edge that samples `irq_wake_i`, and it reads 1 one cycle later.
- R7: Register map and framing:
  - Address 0 is control, with enable at bit 0, master at bit 1, CPOL at bit 2, CPHA at bit 3 and divider select at bits 5:4.
  - Address 1 is status, with the completion flag at bit 7 and busy at bit 6.
  - Address 2 takes the transmit byte on write and returns the last received byte on read. In master mode with enable set, writing it also starts a frame.
  - Frames are 8 bits, most significant bit first. The received byte is copied into the data register when the frame ends.
- R8: Divider select codes 0, 1, 2 and 3 divide the system clock by 2, 4, 16 and 32. This gives a master SCK half period of 1, 2, 8 and 16 clock cycles.
- R9: SCK idles at the CPOL level. With CPHA = 0, data is sampled on the leading SCK edge and changes on the trailing edge. With CPHA = 1, data changes on the leading edge and is sampled on the trailing edge. All four combinations transfer correctly in both roles.
- R10: Writing status with bit 7 set clears the completion flag. Writing status with bit 7 clear leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from address) |
| stop_i | input | 1 | One-cycle request to enter the stop state |
| irq_wake_i | input | 1 | One-cycle IRQ wake that ends the stop state |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| mosi_i | input | 1 | Serial data in, slave mode |
| mosi_o | output | 1 | Serial data out, master mode |
| miso_i | input | 1 | Serial data in, master mode |
| miso_o | output | 1 | Serial data out, slave mode while selected |
| ss_ni | input | 1 | Active-low slave select from an external master |
| ss_no | output | 1 | Active-low slave select driven while a master frame runs |

## Verification
The two functions that can land in one cycle are the completion of a slave frame and the IRQ wake that ends stop. Whether the frame ends just before, exactly on, or just after the wake decides whether the flag goes through the pending latch or is set directly.

The bench provokes the coincidence by halting its external master right after the last sampling edge of a frame. It then issues the wake after a delay that is swept from 0 to 6 cycles, so that one of the offsets meets the completion pulse, which arrives late because of the input synchronizers. Each offset is judged the same way: the flag must read clear just before the wake, it must read set a few cycles after it, and the data register must hold the byte the bench shifted in.

// File: rtl/spi_sf_pkg.sv
package spi_sf_pkg;
  localparam int unsigned REG_AW = 2;
  localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] A_STAT = 2'd1;
  localparam logic [REG_AW-1:0] A_DATA = 2'd2;
  localparam int unsigned HALF_W = 5;

  typedef enum logic [1:0] {
    DIV2  = 2'd0,
    DIV4  = 2'd1,
    DIV16 = 2'd2,
    DIV32 = 2'd3
  } div_e;

  typedef struct packed {
    div_e div;
    logic cpha;
    logic cpol;
    logic master;
    logic en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // SCK half period in system clock cycles
  function automatic logic [HALF_W-1:0] half_of(div_e d);
    case (d)
      DIV2:    return HALF_W'(1);
      DIV4:    return HALF_W'(2);
      DIV16:   return HALF_W'(8);
      default: return HALF_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/spi_sf_sync.sv
module spi_sf_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_sf_baud.sv
module spi_sf_baud
  import spi_sf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              tick_o
);
  logic [HALF_W-1:0] cnt_q;
  logic              last;

  assign last   = (cnt_q == half_i - HALF_W'(1));
  assign tick_o = run_i & last;

  // counter holds when run_i is low: a stopped frame keeps its phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= last ? '0 : cnt_q + HALF_W'(1);
  end
endmodule

// File: rtl/spi_sf_shifter.sv
module spi_sf_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         preload_i,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic         smp_i,
  input  logic         din_i,
  output logic         dout_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  tx_q, rx_q;
  logic [CW-1:0] cnt_q;
  logic          out_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      out_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (wr_i) begin
        // phase 0 puts the first bit on the line before the first edge
        if (preload_i) begin
          out_q <= wdata_i[W-1];
          tx_q  <= {wdata_i[W-2:0], 1'b0};
        end else begin
          tx_q  <= wdata_i;
        end
      end else if (adv_i) begin
        out_q <= tx_q[W-1];
        tx_q  <= {tx_q[W-2:0], 1'b0};
      end
      if (clr_i) begin
        cnt_q <= '0;
      end else if (smp_i) begin
        rx_q  <= {rx_q[W-2:0], din_i};
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(W-1)) done_q <= 1'b1;
      end
    end
  end

  assign dout_o = out_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_stopfreeze.sv
module spi_stopfreeze
  import spi_sf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              stop_i,
  input  logic              irq_wake_i,
  input  logic              sck_i,
  output logic              sck_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              miso_o,
  input  logic              ss_ni,
  output logic              ss_no
);
  localparam int unsigned EDGES  = 2 * DATA_W;
  localparam int unsigned EDGE_W = $clog2(EDGES);

  ctrl_t              ctrl_q;
  logic               stop_q, pend_q, flag_q;
  logic               mbusy_q, sck_q, sck_d_q;
  logic [EDGE_W-1:0]  edge_q;
  logic [DATA_W-1:0]  data_q;

  logic wr_ctrl, wr_stat, wr_data;
  assign wr_ctrl = reg_we_i & (reg_addr_i == A_CTRL);
  assign wr_stat = reg_we_i & (reg_addr_i == A_STAT);
  assign wr_data = reg_we_i & (reg_addr_i == A_DATA);

  // slave inputs
  logic ss_s, sck_s, mosi_s;
  spi_sf_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ss_ni, sck_i, mosi_i}),
    .q_o    ({ss_s, sck_s, mosi_s})
  );

  logic sel, s_rise, s_fall, s_lead, s_trail;
  assign sel     = ctrl_q.en & ~ctrl_q.master & ~ss_s;
  assign s_rise  = sck_s & ~sck_d_q;
  assign s_fall  = ~sck_s & sck_d_q;
  assign s_lead  = sel & (ctrl_q.cpol ? s_fall : s_rise);
  assign s_trail = sel & (ctrl_q.cpol ? s_rise : s_fall);

  // master edge generation
  logic m_start, tick, m_lead, m_trail;
  assign m_start = wr_data & ctrl_q.en & ctrl_q.master & ~mbusy_q & ~stop_q;

  spi_sf_baud u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (m_start),
    .run_i  (mbusy_q & ~stop_q),
    .half_i (half_of(ctrl_q.div)),
    .tick_o (tick)
  );

  assign m_lead  = tick & ~edge_q[0];
  assign m_trail = tick &  edge_q[0];

  logic lead, trail, smp, adv, dout, done;
  logic [DATA_W-1:0] rx;
  assign lead  = ctrl_q.master ? m_lead  : s_lead;
  assign trail = ctrl_q.master ? m_trail : s_trail;
  assign smp   = ctrl_q.cpha ? trail : lead;
  assign adv   = ctrl_q.cpha ? lead  : trail;

  spi_sf_shifter #(.W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_data & ~mbusy_q),
    .wdata_i   (reg_wdata_i),
    .preload_i (~ctrl_q.cpha),
    .clr_i     (m_start | (~ctrl_q.master & ~sel)),
    .adv_i     (adv),
    .smp_i     (smp),
    .din_i     (ctrl_q.master ? miso_i : mosi_s),
    .dout_o    (dout),
    .done_o    (done),
    .rx_o      (rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mbusy_q <= 1'b0;
      edge_q  <= '0;
      sck_q   <= 1'b0;
    end else if (m_start) begin
      mbusy_q <= 1'b1;
      edge_q  <= '0;
      sck_q   <= ctrl_q.cpol;
    end else if (tick) begin
      sck_q  <= ~sck_q;
      edge_q <= edge_q + EDGE_W'(1);
      if (edge_q == EDGE_W'(EDGES-1)) mbusy_q <= 1'b0;
    end else if (!mbusy_q) begin
      sck_q <= ctrl_q.cpol;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      stop_q  <= 1'b0;
      pend_q  <= 1'b0;
      flag_q  <= 1'b0;
      data_q  <= '0;
      sck_d_q <= 1'b0;
    end else begin
      sck_d_q <= sck_s;
      stop_q  <= irq_wake_i ? 1'b0 : (stop_i ? 1'b1 : stop_q);
      // completion seen while stopped waits here until wake
      pend_q  <= stop_q ? (pend_q | done) : 1'b0;
      if ((done | pend_q) & ~stop_q)                flag_q <= 1'b1;
      else if (wr_stat & reg_wdata_i[DATA_W-1])     flag_q <= 1'b0;
      if (done)    data_q <= rx;
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = DATA_W'(ctrl_q);
      A_STAT:  reg_rdata_o = {flag_q, mbusy_q | sel, (DATA_W-2)'(0)};
      A_DATA:  reg_rdata_o = data_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign sck_o  = sck_q;
  assign ss_no  = ~mbusy_q;
  assign mosi_o = ctrl_q.master & dout;
  assign miso_o = sel & dout;
endmodule

// File: rtl/spi_stopfreeze_chk.sv
module spi_stopfreeze_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic stop_q,
  input logic pend_q,
  input logic flag_q,
  input logic mbusy_q,
  input logic sck_q,
  input logic cpol_i,
  input logic sck_o,
  input logic mosi_o
);
  // R1: no master line moves across a held stop
  p_master_freeze_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && $past(stop_q) && mbusy_q) |-> ($stable(sck_o) && $stable(mosi_o)));

  // R5: flag cannot rise from a cycle spent stopped
  p_no_flag_in_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_q) |-> !$rose(flag_q));

  // R6: pending completion posts as soon as stop is gone
  p_pending_posts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !stop_q) |=> flag_q);

  // R9: a finished master frame leaves SCK at its idle level
  p_sck_idle_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mbusy_q) |-> (sck_q == cpol_i));
endmodule

bind spi_stopfreeze spi_stopfreeze_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .stop_q  (stop_q),
  .pend_q  (pend_q),
  .flag_q  (flag_q),
  .mbusy_q (mbusy_q),
  .sck_q   (sck_q),
  .cpol_i  (ctrl_q.cpol),
  .sck_o   (sck_o),
  .mosi_o  (mosi_o)
);

// File: tb/spi_stopfreeze_tb.sv
module spi_stopfreeze_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HP = 6;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'd0;
  logic [7:0] reg_rdata_o;
  logic       stop_i = 1'b0, irq_wake_i = 1'b0;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_ni = 1'b1;
  logic       sck_o, mosi_o, miso_o, ss_no, miso_i;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign miso_i = ~mosi_o;  // inverting loopback for master frames

  spi_stopfreeze u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .stop_i(stop_i),
    .irq_wake_i(irq_wake_i), .sck_i(sck_i), .sck_o(sck_o), .mosi_i(mosi_i),
    .mosi_o(mosi_o), .miso_i(miso_i), .miso_o(miso_o), .ss_ni(ss_ni), .ss_no(ss_no)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); irq_wake_i = 1'b1;
    @(negedge clk); irq_wake_i = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(2'd1, s);
      if (!s[6]) break;
    end
  endtask

  task automatic clear_flag();
    wr(2'd1, 8'h80);
  endtask

  // bench acts as external master; hold_last stops right after the final sampling edge
  task automatic slave_frame(input logic [7:0] m, input bit cpol, input bit cpha,
                             input bit hold_last, output logic [7:0] got);
    got = 8'h00;
    sck_i = cpol;
    cyc(HP);
    ss_ni = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) begin
        mosi_i = m[i];
        cyc(HP);
        got[i] = miso_o;
        sck_i = ~cpol;
        if (i == 0 && hold_last) return;
        cyc(HP);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol;
        mosi_i = m[i];
        cyc(HP);
        got[i] = miso_o;
        sck_i = cpol;
        cyc(HP);
      end
    end
    cyc(HP);
    ss_ni = 1'b1;
    cyc(HP);
  endtask

  task automatic slave_end(input bit cpol);
    sck_i = cpol;
    cyc(HP);
    ss_ni = 1'b1;
    cyc(HP);
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    rd(2'd0, v); chk(v == 8'h00, "R3 ctrl after reset", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R3 status after reset", v, 0);
    chk(sck_o == 1'b0 && ss_no == 1'b1, "R3 pins after reset", {sck_o, ss_no}, 2'b01);
    wr(2'd2, 8'hF0);
    begin
      bit moved = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!ss_no || sck_o) moved = 1;
      end
      chk(!moved, "R3 disabled: data write starts nothing", moved, 0);
    end
  endtask

  task automatic t_master_modes();
    logic [7:0] v, tx;
    for (int m = 0; m < 4; m++) begin
      bit cpol = m[1];
      bit cpha = m[0];
      tx = 8'h6B ^ 8'(m << 3);
      wr(2'd0, {4'b0000, cpha, cpol, 2'b11});
      wr(2'd2, tx);
      wait_idle();
      cyc(2);
      rd(2'd2, v); chk(v == ~tx, "R9 R7 master loopback byte", v, ~tx);
      chk(sck_o == cpol, "R9 sck idle level", sck_o, cpol);
      rd(2'd1, v); chk(v[7] == 1'b1, "R7 flag after master frame", v, 8'h80);
      clear_flag();
    end
  endtask

  task automatic t_baud();
    int half_exp[4] = '{1, 2, 8, 16};
    for (int d = 0; d < 4; d++) begin
      logic prev;
      int n;
      wr(2'd0, {2'b00, 2'(d), 4'b0011});
      wr(2'd2, 8'h55);
      prev = sck_o;
      for (int i = 0; i < 100 && sck_o == prev; i++) @(negedge clk);
      prev = sck_o;
      n = 0;
      do begin @(negedge clk); n++; end while (sck_o == prev && n < 100);
      chk(n == half_exp[d], "R8 sck half period", n, half_exp[d]);
      wait_idle();
      clear_flag();
    end
  endtask

  task automatic t_master_stop();
    logic [7:0] v;
    logic s0, m0;
    bit moved = 0;
    wr(2'd0, 8'h33);  // div32, cpol0, cpha0, master, en
    wr(2'd2, 8'h96);
    cyc(40);
    pulse_stop();
    cyc(1);
    s0 = sck_o; m0 = mosi_o;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sck_o != s0 || mosi_o != m0 || ss_no) moved = 1;
    end
    chk(!moved, "R1 master lines frozen in stop", moved, 0);
    rd(2'd1, v); chk(v[6] == 1'b1 && v[7] == 1'b0, "R1 busy held, no flag", v, 8'h40);
    pulse_wake();
    wait_idle();
    cyc(2);
    rd(2'd2, v); chk(v == 8'h69, "R2 resumed frame byte", v, 8'h69);
    rd(2'd1, v); chk(v[7] == 1'b1, "R2 flag after resume", v, 8'h80);
    clear_flag();
  endtask

  task automatic t_slave_normal();
    logic [7:0] got, v;
    wr(2'd0, 8'h0D);  // cpha1, cpol1, slave, en
    wr(2'd2, 8'hC3);
    slave_frame(8'h81, 1'b1, 1'b1, 1'b0, got);
    chk(got == 8'hC3, "R7 R9 slave miso MSB first", got, 8'hC3);
    cyc(4);
    rd(2'd1, v); chk(v[7] == 1'b1, "R7 slave flag outside stop", v, 8'h80);
    rd(2'd2, v); chk(v == 8'h81, "R7 slave rx byte", v, 8'h81);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk(v[7] == 1'b1, "R10 write 0 keeps flag", v[7], 1);
    wr(2'd1, 8'h80);
    rd(2'd1, v); chk(v[7] == 1'b0, "R10 write 1 clears flag", v[7], 0);
  endtask

  task automatic t_slave_stop();
    logic [7:0] got, v;
    wr(2'd0, 8'h01);  // cpha0, cpol0, slave, en
    wr(2'd2, 8'h3C);
    pulse_stop();
    slave_frame(8'hA5, 1'b0, 1'b0, 1'b0, got);
    chk(got == 8'h3C, "R4 slave drives miso in stop", got, 8'h3C);
    cyc(4);
    rd(2'd1, v); chk(v[7] == 1'b0, "R5 no flag while stopped", v[7], 0);
    rd(2'd2, v); chk(v == 8'hA5, "R4 slave received in stop", v, 8'hA5);
    @(negedge clk); irq_wake_i = 1'b1;
    @(negedge clk); irq_wake_i = 1'b0;
    rd(2'd1, v); chk(v[7] == 1'b0, "R6 flag clear at wake edge", v[7], 0);
    @(negedge clk);
    rd(2'd1, v); chk(v[7] == 1'b1, "R6 flag posted cycle after wake", v[7], 1);
    clear_flag();
  endtask

  task automatic t_wake_sweep();
    logic [7:0] got, v, m;
    for (int off = 0; off < 7; off++) begin
      m = 8'h5A ^ 8'(off);
      wr(2'd0, 8'h01);
      wr(2'd2, 8'h11);
      pulse_stop();
      slave_frame(m, 1'b0, 1'b0, 1'b1, got);
      cyc(off);
      rd(2'd1, v); chk(v[7] == 1'b0, "R5 sweep flag clear before wake", v[7], 0);
      pulse_wake();
      cyc(6);
      rd(2'd1, v); chk(v[7] == 1'b1, "R6 sweep flag after wake", v[7], 1);
      rd(2'd2, v); chk(v == m, "R6 sweep rx byte", v, m);
      slave_end(1'b0);
      clear_flag();
    end
  endtask

  task automatic t_reset_in_stop();
    logic [7:0] v;
    wr(2'd0, 8'h3B);
    wr(2'd2, 8'hE7);
    cyc(30);
    pulse_stop();
    cyc(3);
    @(negedge clk); rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(2);
    rd(2'd0, v); chk(v == 8'h00, "R3 ctrl cleared by reset in stop", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R3 status cleared by reset in stop", v, 0);
    chk(sck_o == 1'b0 && ss_no == 1'b1, "R3 pins after reset in stop", {sck_o, ss_no}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    t_reset_state();
    t_master_modes();
    t_baud();
    t_master_stop();
    t_slave_normal();
    t_slave_stop();
    t_wake_sweep();
    t_reset_in_stop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule